// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter with Capture

This block is a 16-bit peripheral timer/counter built around a count register pair and a second register pair that serves as either a capture target or a reload source. An 8-bit control register selects what it does. In capture mode the counter runs freely and wraps. In auto-reload mode it restarts from the stored value. In baud mode it produces an overflow strobe that paces a serial receiver and transmitter. The counter either advances on an internal machine-cycle tick or counts falling edges on an external count pin. A second pin, the trigger pin, can capture the count or force a reload, depending on the mode.

Software reaches the block through a byte-wide register port. Reads are combinational and writes take effect at the next clock edge. There are five registers: control at address 0, count low/high at 1/2, and capture/reload low/high at 3/4. Addresses 5 to 7 read as zero. The two flag bits raise a single interrupt request, gated by an external enable input. In the interrupt controller this source is served at vector 0x2B.

Control register bits, from bit 7 to bit 0: overflow flag, trigger flag, receive-clock select, transmit-clock select, trigger enable, run, external count select, capture select.

Top module: `cnt16_capture_timer`

## Requirements
- R1: While the run bit (bit 2) is clear, the count never advances, whatever the tick inputs and the count pin do.
- R2: With external count select (bit 1) clear, the count advances once per clock in which `mc_tick` is high. With it set, the count advances once per falling edge on `cnt_pin`, and `mc_tick` is ignored.
- R3: When either clock-select bit (bit 5 or bit 4) is set, baud mode wins over the capture select bit. An overflow reloads the count from the capture register, pulses `baud_ovf` high for one clock, and leaves the overflow flag (bit 7) untouched.
- R4: In baud mode with internal counting, the count advances once per clock in which `baud_tick` is high (six per machine cycle), and `mc_tick` has no effect.
- R5: In capture mode (bit 0 set, baud off), an overflow from 0xFFFF sets the overflow flag and the count wraps to 0x0000.
- R6: In capture mode with trigger enable (bit 3) set, a falling edge on `trig_pin` copies the count after that clock's increment into the capture register and sets the trigger flag (bit 6).
- R7: In auto-reload mode (bit 0 clear, baud off), an overflow sets the overflow flag and loads the count from the capture register.
- R8: In auto-reload mode with trigger enable set, a `trig_pin` falling edge loads the count from the capture register and sets the trigger flag.
- R9: In baud mode with trigger enable set, a `trig_pin` falling edge sets the trigger flag only. The count and the capture register are kept.
- R10: With trigger enable clear, a `trig_pin` falling edge changes no register.
- R11: `irq` is high exactly when `irq_en` is high and the overflow flag or the trigger flag is set. The flags stay set until software writes the control register.
- R12: Reset clears the control, count and capture registers to zero, and `irq` and `baud_ovf` to low.
- R13: Each pin passes through a two-flop synchronizer. A falling edge acts exactly once, at the third rising clock edge after the pin changes, even if the pin then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| mc_tick | input | 1 | Machine-cycle tick |
| baud_tick | input | 1 | Fast baud tick (six per machine cycle) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | Capture/reload trigger pin, asynchronous |
| irq_en | input | 1 | Interrupt enable for this source |
| irq | output | 1 | Interrupt request |
| baud_ovf | output | 1 | One-clock strobe on each baud-mode overflow |

## Verification
A wrong next-count value shows up in the count registers on the first tick after the fault. A wrong mode decode shows up as a missing or extra reload or flag when the count reaches 0xFFFF. The bench therefore sweeps start values close to overflow against tick counts, in all three modes, and compares the count, the overflow flag and the number of baud strobes with an arithmetic model. A trigger edge that is lost, or acted on twice, shows up in the trigger flag or the capture register three clocks after the pin falls. A flag that fails to stay set shows up on `irq` at once.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;

    // control register, bit 7 down to bit 0
    typedef struct packed {
        logic ovf_flag;
        logic trig_flag;
        logic rx_clk_sel;
        logic tx_clk_sel;
        logic trig_en;
        logic run;
        logic ext_cnt;
        logic cap_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_BAUD    = 2'd2
    } mode_t;
endpackage

// File: rtl/tmr16_pin_edge.sv
`timescale 1ns/1ps
module tmr16_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign fall = st_q.last & ~st_q.sync[STAGES-1];
endmodule

// File: rtl/tmr16_mode_dec.sv
`timescale 1ns/1ps
module tmr16_mode_dec
    import tmr16_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  mc_tick,
    input  logic  baud_tick,
    input  logic  cnt_fall,
    output mode_t mode,
    output logic  step
);
    logic int_tick;

    always_comb begin
        if (ctrl.rx_clk_sel || ctrl.tx_clk_sel) mode = MODE_BAUD;
        else if (ctrl.cap_sel)                  mode = MODE_CAPTURE;
        else                                    mode = MODE_RELOAD;
        int_tick = (mode == MODE_BAUD) ? baud_tick : mc_tick;
        step     = ctrl.run & (ctrl.ext_cnt ? cnt_fall : int_tick);
    end
endmodule

// File: rtl/tmr16_count_core.sv
`timescale 1ns/1ps
module tmr16_count_core #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             step,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap
);
    always_comb begin
        wrap = step & (&cnt);
        if (load)      nxt = load_val;
        else if (step) nxt = cnt + WIDTH'(1);
        else           nxt = cnt;
    end
endmodule

// File: rtl/cnt16_capture_timer.sv
`timescale 1ns/1ps
module cnt16_capture_timer
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              mc_tick,
    input  logic              baud_tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              irq_en,
    output logic              irq,
    output logic              baud_ovf
);
    localparam int N_PINS = 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             baud_pulse;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic [N_PINS-1:0] pins, falls;
    logic              cnt_fall, trig_fall, trig_ev;
    mode_t             mode;
    logic              step, wrap, reload;
    logic [CNT_W-1:0]  core_nxt;
    logic [7:0]        ctrl_bits;
    logic [CNT_W-1:0]  cnt_val, cap_val;

    assign pins = {trig_pin, cnt_pin};

    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_pin
        tmr16_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[gi]),
            .fall (falls[gi])
        );
    end

    assign cnt_fall  = falls[0];
    assign trig_fall = falls[1];

    tmr16_mode_dec u_dec (
        .ctrl     (st_q.ctrl),
        .mc_tick  (mc_tick),
        .baud_tick(baud_tick),
        .cnt_fall (cnt_fall),
        .mode     (mode),
        .step     (step)
    );

    assign trig_ev = trig_fall & st_q.ctrl.trig_en;
    assign reload  = ((mode == MODE_RELOAD) & (wrap | trig_ev))
                   | ((mode == MODE_BAUD) & wrap);

    tmr16_count_core #(.WIDTH(CNT_W)) u_core (
        .cnt     (st_q.cnt),
        .step    (step),
        .load    (reload),
        .load_val(st_q.cap),
        .nxt     (core_nxt),
        .wrap    (wrap)
    );

    always_comb begin
        st_d            = st_q;
        st_d.cnt        = core_nxt;
        st_d.baud_pulse = (mode == MODE_BAUD) & wrap;
        if ((mode != MODE_BAUD) && wrap) st_d.ctrl.ovf_flag = 1'b1;
        if (trig_ev)                     st_d.ctrl.trig_flag = 1'b1;
        if ((mode == MODE_CAPTURE) && trig_ev) st_d.cap = core_nxt;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:   st_d.ctrl                 = ctrl_t'(reg_wdata);
                A_CNT_LO: st_d.cnt[BYTE_W-1:0]      = reg_wdata;
                A_CNT_HI: st_d.cnt[CNT_W-1:BYTE_W]  = reg_wdata;
                A_CAP_LO: st_d.cap[BYTE_W-1:0]      = reg_wdata;
                A_CAP_HI: st_d.cap[CNT_W-1:BYTE_W]  = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_bits = st_q.ctrl;
    assign cnt_val   = st_q.cnt;
    assign cap_val   = st_q.cap;

    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_bits;
            A_CNT_LO: reg_rdata = cnt_val[BYTE_W-1:0];
            A_CNT_HI: reg_rdata = cnt_val[CNT_W-1:BYTE_W];
            A_CAP_LO: reg_rdata = cap_val[BYTE_W-1:0];
            A_CAP_HI: reg_rdata = cap_val[CNT_W-1:BYTE_W];
            default:  reg_rdata = '0;
        endcase
    end

    assign irq      = irq_en & (st_q.ctrl.ovf_flag | st_q.ctrl.trig_flag);
    assign baud_ovf = st_q.baud_pulse;
endmodule

// File: rtl/tmr16_checker.sv
`timescale 1ns/1ps
module tmr16_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        irq_en,
    input logic        irq,
    input logic        baud_ovf,
    input logic [7:0]  ctrl,
    input logic [15:0] cnt,
    input logic [15:0] cap
);
    logic baud;
    assign baud = ctrl[5] | ctrl[4];

    assert_stopped_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !ctrl[3] && !reg_wr) |=> $stable(cnt));

    assert_baud_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ctrl[7] && !reg_wr) |=> !ctrl[7]);

    assert_baud_strobe_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ovf |-> $past(baud));

    assert_baud_reloaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_ovf && !$past(reg_wr)) |-> (cnt == cap));

    assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl[6]) && $past(ctrl[0] && !baud && !reg_wr)) |-> (cap == cnt));

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && !reg_wr) |=> ctrl[7]);

    assert_reset_zero_R12: assert property (@(posedge clk)
        !rst_n |=> (ctrl == 8'h00 && cnt == 16'h0000 && cap == 16'h0000 && !baud_ovf));
endmodule

bind cnt16_capture_timer tmr16_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .irq_en  (irq_en),
    .irq     (irq),
    .baud_ovf(baud_ovf),
    .ctrl    (ctrl_bits),
    .cnt     (cnt_val),
    .cap     (cap_val)
);

// File: tb/tb_cnt16_capture_timer.sv
`timescale 1ns/1ps
module tb_cnt16_capture_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mc_tick = 1'b0, baud_tick = 1'b0;
    logic       cnt_pin = 1'b1, trig_pin = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq, baud_ovf;

    int errors = 0;
    int checks = 0;
    int ovf_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cnt16_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mc_tick(mc_tick),
        .baud_tick(baud_tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .irq_en(irq_en), .irq(irq), .baud_ovf(baud_ovf)
    );

    always @(negedge clk) if (baud_ovf) ovf_seen++;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] p, input logic [7:0] ct);
        wr(3'd0, 8'h00);
        wr(3'd1, c[7:0]);
        wr(3'd2, c[15:8]);
        wr(3'd3, p[7:0]);
        wr(3'd4, p[15:8]);
        wr(3'd0, ct);
    endtask

    task automatic pulse_mc(input int n);
        @(negedge clk);
        mc_tick = 1'b1;
        repeat (n) @(negedge clk);
        mc_tick = 1'b0;
    endtask

    task automatic pulse_baud(input int n);
        @(negedge clk);
        baud_tick = 1'b1;
        repeat (n) @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic cnt_edge();
        @(negedge clk); cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_edge();
        @(negedge clk); trig_pin = 1'b0;
        repeat (5) @(negedge clk);
        trig_pin = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // mode: 0 reload, 1 capture, 2 baud
    function automatic void model(input int mode, input logic [15:0] start,
                                  input logic [15:0] cap, input int n,
                                  output logic [15:0] c, output logic tf, output int novf);
        c = start; tf = 1'b0; novf = 0;
        for (int i = 0; i < n; i++) begin
            if (c == 16'hFFFF) begin
                if (mode == 2) novf++;
                else tf = 1'b1;
                c = (mode == 1) ? 16'h0000 : cap;
            end else begin
                c = c + 16'd1;
            end
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w, ec;
        logic        etf;
        int          eovf;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(3'd0, b);  chk(b == 8'h00, "R12 ctrl", b, 0);
        rd16(3'd1, w); chk(w == 16'h0, "R12 count", w, 0);
        rd16(3'd3, w); chk(w == 16'h0, "R12 capture", w, 0);
        chk(irq == 1'b0 && baud_ovf == 1'b0, "R12 outputs", {irq, baud_ovf}, 0);

        // R1 stopped: no source advances the count
        setup(16'h1234, 16'h0000, 8'h00);
        pulse_mc(10); pulse_baud(10); cnt_edge();
        rd16(3'd1, w); chk(w == 16'h1234, "R1 stopped", w, 16'h1234);
        setup(16'h1234, 16'h0000, 8'h22);
        pulse_mc(7); pulse_baud(7); cnt_edge();
        rd16(3'd1, w); chk(w == 16'h1234, "R1 stopped baud", w, 16'h1234);

        // R2 external count: edges counted, mc_tick ignored
        setup(16'h00FE, 16'h0000, 8'h06);
        mc_tick = 1'b1;
        for (int k = 0; k < 5; k++) cnt_edge();
        mc_tick = 1'b0;
        rd16(3'd1, w); chk(w == 16'h0103, "R2 edge count", w, 16'h0103);
        // R13 pin held low counts once
        @(negedge clk); cnt_pin = 1'b0;
        repeat (20) @(negedge clk);
        rd16(3'd1, w); chk(w == 16'h0104, "R13 single edge", w, 16'h0104);
        cnt_pin = 1'b1; repeat (4) @(negedge clk);

        // R4 baud internal: mc_tick ignored, baud_tick counts
        setup(16'h0100, 16'h0000, 8'h24);
        pulse_mc(10);
        rd16(3'd1, w); chk(w == 16'h0100, "R4 mc ignored", w, 16'h0100);
        pulse_baud(6);
        rd16(3'd1, w); chk(w == 16'h0106, "R4 baud ticks", w, 16'h0106);

        // Sweep near overflow: R5 capture, R7 reload, R3 baud
        for (int mode = 0; mode < 3; mode++) begin
            for (int s = 0; s < 16; s++) begin
                for (int n = 1; n <= 18; n++) begin
                    logic [7:0]  ct;
                    logic [15:0] st;
                    st = 16'hFFF0 + 16'(s);
                    ct = (mode == 0) ? 8'h04 : (mode == 1) ? 8'h05 :
                         ((s % 2 == 0) ? 8'h25 : 8'h14);
                    setup(st, 16'hFFF4, ct);
                    ovf_seen = 0;
                    if (mode == 2) pulse_baud(n); else pulse_mc(n);
                    model(mode, st, 16'hFFF4, n, ec, etf, eovf);
                    rd16(3'd1, w);
                    rd(3'd0, b);
                    if (mode == 0) begin
                        chk(w == ec, "R7 reload count", w, ec);
                        chk(b[7] == etf, "R7 reload flag", b[7], etf);
                    end else if (mode == 1) begin
                        chk(w == ec, "R5 capture wrap count", w, ec);
                        chk(b[7] == etf, "R5 capture flag", b[7], etf);
                    end else begin
                        chk(w == ec, "R3 baud reload count", w, ec);
                        chk(b[7] == 1'b0, "R3 baud no flag", b[7], 0);
                    end
                    chk(ovf_seen == eovf, "R3 baud strobes", ovf_seen, eovf);
                end
            end
        end

        // R11 irq from overflow flag
        setup(16'hFFFF, 16'h0010, 8'h04);
        irq_en = 1'b1;
        pulse_mc(1);
        rd16(3'd1, w); chk(w == 16'h0010, "R7 reload value", w, 16'h0010);
        chk(irq == 1'b1, "R11 irq on overflow", irq, 1);
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R11 flag sticky", irq, 1);
        irq_en = 1'b0; #1;
        chk(irq == 1'b0, "R11 irq gated", irq, 0);

        // R6 capture trigger
        setup(16'h1234, 16'h0000, 8'h09);
        irq_en = 1'b1;
        trig_edge();
        rd16(3'd3, w); chk(w == 16'h1234, "R6 captured", w, 16'h1234);
        rd(3'd0, b);   chk(b == 8'h49, "R6 trig flag", b, 8'h49);
        chk(irq == 1'b1, "R11 irq on trig flag", irq, 1);
        wr(3'd0, 8'h09); #1;
        chk(irq == 1'b0, "R11 cleared by write", irq, 0);
        irq_en = 1'b0;

        // R13 trigger held low acts once; cleared flag stays clear
        @(negedge clk); trig_pin = 1'b0;
        repeat (5) @(negedge clk);
        wr(3'd0, 8'h09);
        repeat (10) @(negedge clk);
        rd(3'd0, b); chk(b == 8'h09, "R13 trig once", b, 8'h09);
        trig_pin = 1'b1; repeat (5) @(negedge clk);

        // R6 capture while running (capture value equals count after capture)
        setup(16'h2000, 16'h0000, 8'h0D);
        @(negedge clk); mc_tick = 1'b1; trig_pin = 1'b0;
        repeat (3) @(negedge clk);  // trigger acts on third posedge
        mc_tick = 1'b0;
        rd16(3'd3, w); chk(w == 16'h2003, "R6 capture running", w, 16'h2003);
        trig_pin = 1'b1; repeat (5) @(negedge clk);

        // R8 reload trigger
        setup(16'h1234, 16'hABCD, 8'h08);
        trig_edge();
        rd16(3'd1, w); chk(w == 16'hABCD, "R8 trig reload", w, 16'hABCD);
        rd(3'd0, b);   chk(b == 8'h48, "R8 trig flag", b, 8'h48);

        // R9 baud trigger: flag only
        setup(16'h1234, 16'hABCD, 8'h28);
        trig_edge();
        rd16(3'd1, w); chk(w == 16'h1234, "R9 count kept", w, 16'h1234);
        rd16(3'd3, w); chk(w == 16'hABCD, "R9 capture kept", w, 16'hABCD);
        rd(3'd0, b);   chk(b == 8'h68, "R9 trig flag", b, 8'h68);

        // R10 trigger disabled
        setup(16'h1234, 16'hABCD, 8'h01);
        trig_edge();
        rd16(3'd3, w); chk(w == 16'hABCD, "R10 capture ignored", w, 16'hABCD);
        rd(3'd0, b);   chk(b == 8'h01, "R10 no flag", b, 8'h01);
        setup(16'h1234, 16'hABCD, 8'h00);
        trig_edge();
        rd16(3'd1, w); chk(w == 16'h1234, "R10 reload ignored", w, 16'h1234);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule